// File: doc/BRIEF.md
# Inverse Number Theoretic Transform Engine

This block turns a vector of N residues modulo a prime q, held in a small on-chip coefficient RAM, back from the evaluation domain into polynomial coefficients, in place. It is the closing step of a negacyclic polynomial product. The RAM is filled in bit-reversed slot order and a twiddle RAM holds powers of the inverse 2N-th root of unity. A single start pulse then runs log2(N) stages of decimation-in-frequency butterflies. When the engine finishes, the coefficients sit in natural order and are already multiplied by 1/N.

The 1/N factor needs no separate pass. Each butterfly output is halved modulo q with a shift, a parity test and one add, and log2(N) halvings give 1/N. Twiddle products are reduced by a Barrett reducer that needs at most one corrective subtraction. The engine issues one butterfly per clock. Between stages it drains its two-deep pipeline, so that no stage reads a slot whose new value has not yet been written.

Top module: `ntt_gs_inverse`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: A start pulse sampled while idle raises `busy` at the next edge. `done` is a one-cycle pulse that appears exactly log2(N)·(N/2+3) clock edges after the edge that sampled start, and `busy` is low in the cycle `done` is high and afterwards.
- R3: Stage s (s = 0 … log2(N)−1) uses half-span k = 2^s and group count m = N/2^(s+1). Group i pairs slot j with slot j+k for j in [2ik, 2ik+k−1], and uses twiddle slot m+i. Each pair becomes ((x+y)/2, w·(x−y)/2) mod q.
- R4: Coefficient slot j is loaded with A(ψ^(2·br(j)+1)), where A(X)=Σ a_i X^i and br reverses log2(N) bits. Twiddle slot t holds ψ^(−br(t)). Under these conditions, slot i holds a_i after `done`.
- R5: The 1/N scaling is complete without any extra pass. An input of all ones (the image of a_0 = 1) returns exactly 1 in slot 0 and 0 elsewhere.
- R6: Every value the engine writes, and every value read back, is less than q.
- R7: The first butterfly of a stage is issued only after every write of the previous stage has landed. Each stage inserts three drain cycles, and results stay exact across all stage boundaries.
- R8: Writes on either RAM write port while `busy` is high are ignored.
- R9: A start pulse while `busy` is high neither restarts nor extends the run.
- R10: `coef_rdata` shows the coefficient at `coef_addr` one clock edge after the address is presented, whether or not the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform when idle |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| coef_we | input | 1 | Coefficient RAM write enable (idle only) |
| coef_addr | input | log2(N) | Coefficient RAM address for load and unload |
| coef_wdata | input | len(q) | Coefficient write data |
| coef_rdata | output | len(q) | Registered coefficient read data |
| tw_we | input | 1 | Twiddle RAM write enable (idle only) |
| tw_addr | input | log2(N) | Twiddle RAM address |
| tw_wdata | input | len(q) | Twiddle write data |

## Verification
The hardest condition to reach from the ports is a stage boundary where a stale read would silently corrupt the result. Such a read changes a value only when the slot being read depends on a write that is still in flight. For that reason the bench runs several dense vectors: all values q−1, a ramp, and pseudo-random data, each passed through an arithmetic forward negacyclic evaluation. It also times `done` to the exact edge. Attempted writes and a second start are injected in the middle of a run, and the vector is read back afterwards. A later run that uses the same twiddle table confirms that the table was not disturbed.

// File: rtl/ntt_pkg.sv
package ntt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ntt_barrett.sv
// Barrett reducer with a single corrective subtraction: operand < q^2.
module ntt_barrett #(
    parameter int Q = 7681,
    localparam int DW = $clog2(Q + 1)
) (
    input  logic [2*DW-1:0] prod,
    output logic [DW-1:0]   rem
);
    localparam longint unsigned MU_L = (64'd1 << (2 * DW + 1)) / 64'(Q);
    localparam logic [DW+1:0]   MU_V = (DW + 2)'(MU_L);
    localparam logic [DW:0]     Q_V  = (DW + 1)'(Q);
    localparam logic [DW+1:0]   Q_X  = (DW + 2)'(Q);

    logic [DW+1:0]   c_top;
    logic [2*DW+3:0] c_mu;
    logic [DW:0]     quot;
    logic [2*DW+1:0] quot_q;
    logic [DW+1:0]   raw;

    always_comb begin
        c_top  = prod[2*DW-1:DW-2];
        c_mu   = {{(DW + 2){1'b0}}, c_top} * {{(DW + 2){1'b0}}, MU_V};
        quot   = c_mu[2*DW+3:DW+3];
        quot_q = {{(DW + 1){1'b0}}, quot} * {{(DW + 1){1'b0}}, Q_V};
        raw    = prod[DW+1:0] - quot_q[DW+1:0];
        if (raw >= Q_X) begin
            rem = DW'(raw - Q_X);
        end else begin
            rem = raw[DW-1:0];
        end
    end
endmodule

// File: rtl/ntt_sched.sv
// Stage / group / offset sequencer with an inter-stage drain.
module ntt_sched
    import ntt_pkg::*;
#(
    parameter int N = 16,
    localparam int AW = $clog2(N),
    localparam int SW = $clog2(AW + 1),
    localparam int HALF = N / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pipe_busy,
    output logic          issue,
    output logic [AW-1:0] idx_lo,
    output logic [AW-1:0] idx_hi,
    output logic [AW-1:0] tw_idx,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        seq_state_e    st;
        logic [SW-1:0] stage;
        logic [AW-1:0] bfly;
        logic          done;
    } sched_t;

    sched_t sched_d, sched_q;
    logic [AW-1:0] span, grp, off;

    always_comb begin
        sched_d      = sched_q;
        sched_d.done = 1'b0;
        unique case (sched_q.st)
            ST_IDLE: begin
                if (start) begin
                    sched_d.st    = ST_RUN;
                    sched_d.stage = '0;
                    sched_d.bfly  = '0;
                end
            end
            ST_RUN: begin
                if (sched_q.bfly == AW'(HALF - 1)) begin
                    sched_d.st   = ST_DRAIN;
                    sched_d.bfly = '0;
                end else begin
                    sched_d.bfly = sched_q.bfly + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!pipe_busy) begin
                    if (sched_q.stage == SW'(AW - 1)) begin
                        sched_d.st   = ST_IDLE;
                        sched_d.done = 1'b1;
                    end else begin
                        sched_d.stage = sched_q.stage + 1'b1;
                        sched_d.st    = ST_RUN;
                    end
                end
            end
            default: begin
                sched_d    = '0;
                sched_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q    <= '0;
            sched_q.st <= ST_IDLE;
        end else begin
            sched_q <= sched_d;
        end
    end

    always_comb begin
        span   = AW'(1) << sched_q.stage;
        grp    = sched_q.bfly >> sched_q.stage;
        off    = sched_q.bfly & (span - 1'b1);
        idx_lo = (grp << (sched_q.stage + 1'b1)) | off;
        idx_hi = idx_lo | span;
        tw_idx = (AW'(HALF) >> sched_q.stage) + grp;
        issue  = (sched_q.st == ST_RUN);
        busy   = (sched_q.st != ST_IDLE);
        done   = sched_q.done;
    end

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    tw_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (tw_idx != '0));
endmodule

// File: rtl/ntt_bfly.sv
// Two-register butterfly pipeline: modular sum/difference, then twiddle
// product, Barrett reduction and halving of both outputs.
module ntt_bfly #(
    parameter int Q = 7681,
    parameter int AW = 4,
    localparam int DW = $clog2(Q + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [DW-1:0] in_w,
    input  logic [AW-1:0] in_lo,
    input  logic [AW-1:0] in_hi,
    output logic          out_vld,
    output logic [DW-1:0] out_x,
    output logic [DW-1:0] out_y,
    output logic [AW-1:0] out_lo,
    output logic [AW-1:0] out_hi,
    output logic          busy
);
    localparam logic [DW-1:0] QW = DW'(Q);
    localparam logic [DW-1:0] HQ = DW'((Q + 1) / 2);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] sum;
        logic [DW-1:0] dif;
        logic [DW-1:0] tw;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } s1_t;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    logic [DW:0]     sum_w;
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   red;

    function automatic logic [DW-1:0] halve(input logic [DW-1:0] v);
        return (v >> 1) + (v[0] ? HQ : '0);
    endfunction

    ntt_barrett #(.Q(Q)) u_red (
        .prod (prod),
        .rem  (red)
    );

    always_comb begin
        sum_w = {1'b0, in_a} + {1'b0, in_b};
        s1_d.vld = in_vld;
        s1_d.tw  = in_w;
        s1_d.lo  = in_lo;
        s1_d.hi  = in_hi;
        if (sum_w >= {1'b0, QW}) begin
            s1_d.sum = DW'(sum_w - {1'b0, QW});
        end else begin
            s1_d.sum = sum_w[DW-1:0];
        end
        if (in_a >= in_b) begin
            s1_d.dif = in_a - in_b;
        end else begin
            s1_d.dif = DW'({1'b0, in_a} + {1'b0, QW} - {1'b0, in_b});
        end

        prod    = {{DW{1'b0}}, s1_q.dif} * {{DW{1'b0}}, s1_q.tw};
        s2_d.vld = s1_q.vld;
        s2_d.x   = halve(s1_q.sum);
        s2_d.y   = halve(red);
        s2_d.lo  = s1_q.lo;
        s2_d.hi  = s1_q.hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_vld = s2_q.vld;
    assign out_x   = s2_q.x;
    assign out_y   = s2_q.y;
    assign out_lo  = s2_q.lo;
    assign out_hi  = s2_q.hi;
    assign busy    = s1_q.vld | s2_q.vld;

    // R6
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_x < QW && out_y < QW));
endmodule

// File: rtl/ntt_gs_inverse.sv
module ntt_gs_inverse #(
    parameter int N = 16,
    parameter int Q = 7681,
    localparam int AW = $clog2(N),
    localparam int DW = $clog2(Q + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic          coef_we,
    input  logic [AW-1:0] coef_addr,
    input  logic [DW-1:0] coef_wdata,
    output logic [DW-1:0] coef_rdata,
    input  logic          tw_we,
    input  logic [AW-1:0] tw_addr,
    input  logic [DW-1:0] tw_wdata
);
    logic [DW-1:0] coef_mem [N];
    logic [DW-1:0] tw_mem   [N];

    logic          issue, pipe_busy, wb_vld;
    logic [AW-1:0] idx_lo, idx_hi, tw_idx, wb_lo, wb_hi;
    logic [DW-1:0] wb_x, wb_y;
    logic [DW-1:0] rd_d, rd_q;

    ntt_sched #(.N(N)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pipe_busy (pipe_busy),
        .issue     (issue),
        .idx_lo    (idx_lo),
        .idx_hi    (idx_hi),
        .tw_idx    (tw_idx),
        .busy      (busy),
        .done      (done)
    );

    ntt_bfly #(.Q(Q), .AW(AW)) u_bfly (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (issue),
        .in_a    (coef_mem[idx_lo]),
        .in_b    (coef_mem[idx_hi]),
        .in_w    (tw_mem[tw_idx]),
        .in_lo   (idx_lo),
        .in_hi   (idx_hi),
        .out_vld (wb_vld),
        .out_x   (wb_x),
        .out_y   (wb_y),
        .out_lo  (wb_lo),
        .out_hi  (wb_hi),
        .busy    (pipe_busy)
    );

    always_ff @(posedge clk) begin
        if (wb_vld) begin
            coef_mem[wb_lo] <= wb_x;
            coef_mem[wb_hi] <= wb_y;
        end else if (coef_we && !busy) begin
            coef_mem[coef_addr] <= coef_wdata;
        end
        if (tw_we && !busy) begin
            tw_mem[tw_addr] <= tw_wdata;
        end
    end

    always_comb begin
        rd_d = coef_mem[coef_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign coef_rdata = rd_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    stage_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !$past(issue)) |-> !pipe_busy);

    // R3
    wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> (wb_lo != wb_hi));

    // R8
    wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> busy);
endmodule

// File: tb/ntt_gs_inverse_bench.sv
module ntt_gs_inverse_bench;
    localparam int N  = 16;
    localparam int Q  = 7681;
    localparam int AW = $clog2(N);
    localparam int DW = $clog2(Q + 1);
    localparam int LAT = AW * (N / 2 + 3);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done;
    logic          coef_we = 1'b0;
    logic [AW-1:0] coef_addr = '0;
    logic [DW-1:0] coef_wdata = '0;
    logic [DW-1:0] coef_rdata;
    logic          tw_we = 1'b0;
    logic [AW-1:0] tw_addr = '0;
    logic [DW-1:0] tw_wdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    longint psi, psi_inv;
    longint vec [N];
    longint img [N];

    always #5 clk = ~clk;

    ntt_gs_inverse #(.N(N), .Q(Q)) u_ntt_gs_inverse (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_wdata (coef_wdata),
        .coef_rdata (coef_rdata),
        .tw_we      (tw_we),
        .tw_addr    (tw_addr),
        .tw_wdata   (tw_wdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input bit ok, input longint act,
                       input longint exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint pw(input longint b, input longint e);
        longint r = 1;
        longint x = b % Q;
        longint k = e;
        while (k > 0) begin
            if (k[0]) r = (r * x) % Q;
            x = (x * x) % Q;
            k = k >> 1;
        end
        return r;
    endfunction

    function automatic int brev(input int v);
        int r = 0;
        for (int b = 0; b < AW; b++) begin
            if (v[b]) r = r | (1 << (AW - 1 - b));
        end
        return r;
    endfunction

    task automatic wr_coef(input int a, input longint d);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = AW'(a); coef_wdata = DW'(d);
        @(posedge clk);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic wr_tw(input int a, input longint d);
        @(negedge clk);
        tw_we = 1'b1; tw_addr = AW'(a); tw_wdata = DW'(d);
        @(posedge clk);
        @(negedge clk);
        tw_we = 1'b0;
    endtask

    task automatic rd_coef(input int a, output longint d);
        @(negedge clk);
        coef_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        d = longint'(coef_rdata);
    endtask

    // Forward negacyclic evaluation in bit-reversed slot order
    task automatic make_image();
        for (int j = 0; j < N; j++) begin
            longint acc = 0;
            for (int i = 0; i < N; i++) begin
                longint e = (longint'(2 * brev(j) + 1) * i) % (2 * N);
                acc = (acc + vec[i] * pw(psi, e)) % Q;
            end
            img[j] = acc;
        end
    endtask

    // mode 0 plain, 1 writes during busy, 2 start during busy
    task automatic run(input int mode, input string tag);
        int cyc = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R2", busy == 1'b1, busy, 1, {tag, " busy after start"});
        while (!done && cyc < 1000) begin
            if (mode == 1 && cyc == 10) begin
                coef_we = 1'b1; coef_addr = 3; coef_wdata = 5;
                tw_we = 1'b1; tw_addr = 5; tw_wdata = 9;
            end else if (mode == 2 && cyc == 10) begin
                start = 1'b1;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
            coef_we = 1'b0; tw_we = 1'b0; start = 1'b0;
        end
        if (mode == 2) chk("R9", cyc == LAT, cyc, LAT, {tag, " latency with extra start"});
        else chk("R2", cyc == LAT, cyc, LAT, {tag, " done latency"});
        chk("R2", busy == 1'b0, busy, 0, {tag, " busy with done"});
        @(posedge clk);
        @(negedge clk);
        chk("R2", done == 1'b0, done, 0, {tag, " done one cycle"});
        if (mode == 2) begin
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (busy || done) break;
            end
            chk("R9", busy == 1'b0, busy, 0, {tag, " no relaunch"});
        end
    endtask

    task automatic do_vec(input int mode, input string req, input string tag);
        longint got;
        make_image();
        for (int j = 0; j < N; j++) wr_coef(j, img[j]);
        for (int j = 0; j < N; j++) begin
            rd_coef(j, got);
            chk("R10", got == img[j], got, img[j], {tag, " load readback"});
        end
        run(mode, tag);
        for (int i = 0; i < N; i++) begin
            rd_coef(i, got);
            chk(req, got == vec[i], got, vec[i], {tag, " coefficient"});
            chk("R6", got < Q, got, Q - 1, {tag, " reduced"});
        end
    endtask

    initial begin
        psi = 0;
        for (longint g = 2; g < Q && psi == 0; g++) begin
            if (pw(g, N) == Q - 1) psi = g;
        end
        psi_inv = pw(psi, Q - 2);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1", busy == 1'b0, busy, 0, "busy after reset");
        chk("R1", done == 1'b0, done, 0, "done after reset");
        rst_n = 1'b1;

        for (int t = 0; t < N; t++) wr_tw(t, pw(psi_inv, brev(t)));

        for (int i = 0; i < N; i++) vec[i] = 0;
        do_vec(0, "R4", "zeros");

        for (int i = 0; i < N; i++) vec[i] = (i == 0) ? 1 : 0;
        do_vec(0, "R5", "unit");

        for (int i = 0; i < N; i++) vec[i] = (i == N - 1) ? Q - 1 : 0;
        do_vec(0, "R3", "top slot");

        for (int i = 0; i < N; i++) vec[i] = Q - 1;
        do_vec(0, "R7", "all max");

        for (int i = 0; i < N; i++) vec[i] = (i * 479 + 3) % Q;
        do_vec(0, "R4", "ramp");

        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < N; i++) vec[i] = (k * 7919 + i * i * 131 + i * 17 + 1) % Q;
            do_vec(0, "R7", "random");
        end

        for (int i = 0; i < N; i++) vec[i] = (i * 2311 + 57) % Q;
        do_vec(1, "R8", "busy writes");

        for (int i = 0; i < N; i++) vec[i] = (i * 977 + 4000) % Q;
        do_vec(2, "R8", "table intact");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule